// File: doc/BRIEF.md
# Dual-Processor GPIO Interrupt Routing

This block is the interrupt side of a 32-line general-purpose I/O unit that serves two processors. The input lines pass through a short synchroniser. An optional per-line inversion turns them into a single "data-in" view. Rising transitions of that view are recorded in one sticky edge-cause register, which both processors share. Each processor owns a private pair of enables: an edge enable, which selects which latched edges it sees, and a level enable, which selects which live data-in lines it sees.

For each processor, a line requests service when it is level-enabled and its data-in is high, or when it is edge-enabled and its cause bit is set. The per-line requests are ORed in groups of eight lines. This yields a registered 4-bit summary vector for each processor, and an interrupt controller above the block consumes that vector. Software clears a cause bit by writing 0 to that bit position in the cause register; writing 1 leaves the bit alone.

Top module: `dual_cpu_gpio_irq`

## Requirements
- R1: After reset, both summary vectors are zero, and the cause register and all four enable registers read as zero.
- R2: The enable registers sit at offsets 0x18 (processor 0 edge), 0x1C (processor 0 level), 0x30 (processor 1 edge) and 0x34 (processor 1 level). Each one reads back the last value written to it.
- R3: The inversion register sits at 0x0C. Offset 0x10 reads the data-in view, which equals the synchronised lines XOR the inversion register.
- R4: A 0-to-1 transition of a data-in bit sets the matching bit of the cause register at offset 0x14. The bit stays set until software clears it.
- R5: A write to 0x14 clears every cause bit where the written data has a 0 and leaves every bit where it has a 1 unchanged.
- R6: If a clearing write and a new edge hit the same cause bit in the same cycle, the bit ends up set.
- R7: Bit g of a processor's summary vector is the OR, over lines 8g to 8g+7, of (data-in AND that processor's level enable) OR (cause AND that processor's edge enable).
- R8: One processor's enables have no effect on the other processor's summary vector.
- R9: A summary vector changes one clock cycle after the enable or cause change that causes it.
- R10: Writes to unmapped offsets and to the read-only data-in offset change no register. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous GPIO input lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_cpu0 | output | 4 | Processor 0 grouped interrupt summary |
| irq_cpu1 | output | 4 | Processor 1 grouped interrupt summary |

## Verification
The bound checker watches the cause register on every cycle. It checks that a detected edge always lands in the cause register (even against a clearing write), that a clear removes only zero-written bits, and that bits never vanish without a write. It also checks that each summary vector is the grouped, masked request of the previous cycle, and that an all-zero enable pair keeps its processor quiet. The register offsets, the inversion of the input lines through the synchroniser, and the exact cycle of the collision between a clear and an edge can only be shown by the bench's scenarios. The same holds for the per-line, per-processor sweep that shows each line reaching exactly one group bit of exactly one processor.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PINS       = 32;
    localparam int GRP_W      = 8;
    localparam int NGRP       = PINS / GRP_W;
    localparam int ADDR_W     = 8;
    localparam int NCPU       = 2;
    localparam int SYNC_DEPTH = 2;

    typedef logic [PINS-1:0]   pin_vec_t;
    typedef logic [NGRP-1:0]   grp_vec_t;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    typedef struct packed {
        logic      we;
        reg_addr_t addr;
        pin_vec_t  data;
    } reg_wr_t;

    localparam reg_addr_t REG_POL   = 8'h0C;
    localparam reg_addr_t REG_DIN   = 8'h10;
    localparam reg_addr_t REG_CAUSE = 8'h14;
    localparam reg_addr_t REG_EMSK0 = 8'h18;
    localparam reg_addr_t REG_LMSK0 = 8'h1C;
    localparam reg_addr_t REG_EMSK1 = 8'h30;
    localparam reg_addr_t REG_LMSK1 = 8'h34;

    function automatic reg_addr_t edge_ofs(input int cpu);
        return (cpu == 0) ? REG_EMSK0 : REG_EMSK1;
    endfunction

    function automatic reg_addr_t lvl_ofs(input int cpu);
        return (cpu == 0) ? REG_LMSK0 : REG_LMSK1;
    endfunction

    function automatic grp_vec_t group_or(input pin_vec_t v);
        grp_vec_t g;
        g = '0;
        for (int i = 0; i < PINS; i++) begin
            g[i / GRP_W] = g[i / GRP_W] | v[i];
        end
        return g;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_irq_pkg::*;
#(
    parameter int DEPTH = SYNC_DEPTH
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_vec_t pins_i,
    input  reg_wr_t  wr_i,
    output pin_vec_t pol_o,
    output pin_vec_t data_in_o
);

    pin_vec_t sq [DEPTH];
    pin_vec_t pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq[0] <= '0;
        end else begin
            sq[0] <= pins_i;
        end
    end

    generate
        for (genvar s = 1; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sq[s] <= '0;
                end else begin
                    sq[s] <= sq[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= '0;
        end else if (wr_i.we && wr_i.addr == REG_POL) begin
            pol_q <= wr_i.data;
        end
    end

    assign pol_o     = pol_q;
    assign data_in_o = sq[DEPTH-1] ^ pol_q;

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr_i,
    input  pin_vec_t data_in_i,
    output pin_vec_t rise_o,
    output pin_vec_t cause_o
);

    pin_vec_t prev_q;
    pin_vec_t cause_q;
    pin_vec_t keep;
    pin_vec_t rise;

    assign rise = data_in_i & ~prev_q;

    // Zero bits of a cause write clear; new edges are ORed in afterwards so they win.
    always_comb begin
        keep = '1;
        if (wr_i.we && wr_i.addr == REG_CAUSE) begin
            keep = wr_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            cause_q <= '0;
        end else begin
            prev_q  <= data_in_i;
            cause_q <= (cause_q & keep) | rise;
        end
    end

    assign rise_o  = rise;
    assign cause_o = cause_q;

endmodule

// File: rtl/gpio_cpu_route.sv
module gpio_cpu_route
    import gpio_irq_pkg::*;
#(
    parameter int CPU_ID = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  reg_wr_t   wr_i,
    input  reg_addr_t rd_addr_i,
    input  pin_vec_t  data_in_i,
    input  pin_vec_t  cause_i,
    output pin_vec_t  emsk_o,
    output pin_vec_t  lmsk_o,
    output logic      rd_hit_o,
    output pin_vec_t  rd_data_o,
    output grp_vec_t  irq_o
);

    localparam reg_addr_t E_OFS = edge_ofs(CPU_ID);
    localparam reg_addr_t L_OFS = lvl_ofs(CPU_ID);

    pin_vec_t emsk_q;
    pin_vec_t lmsk_q;
    pin_vec_t req;
    grp_vec_t irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            emsk_q <= '0;
            lmsk_q <= '0;
        end else if (wr_i.we) begin
            if (wr_i.addr == E_OFS) emsk_q <= wr_i.data;
            if (wr_i.addr == L_OFS) lmsk_q <= wr_i.data;
        end
    end

    assign req = (data_in_i & lmsk_q) | (cause_i & emsk_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= group_or(req);
        end
    end

    always_comb begin
        rd_hit_o  = 1'b0;
        rd_data_o = '0;
        if (rd_addr_i == E_OFS) begin
            rd_hit_o  = 1'b1;
            rd_data_o = emsk_q;
        end else if (rd_addr_i == L_OFS) begin
            rd_hit_o  = 1'b1;
            rd_data_o = lmsk_q;
        end
    end

    assign emsk_o = emsk_q;
    assign lmsk_o = lmsk_q;
    assign irq_o  = irq_q;

endmodule

// File: rtl/dual_cpu_gpio_irq.sv
module dual_cpu_gpio_irq
    import gpio_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pin_i,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic [3:0]  irq_cpu0,
    output logic [3:0]  irq_cpu1
);

    reg_wr_t                    wr;
    pin_vec_t                   pol;
    pin_vec_t                   data_in;
    pin_vec_t                   rise;
    pin_vec_t                   cause;
    logic [NCPU-1:0][PINS-1:0]  emsk;
    logic [NCPU-1:0][PINS-1:0]  lmsk;
    logic [NCPU-1:0][PINS-1:0]  rd_val;
    logic [NCPU-1:0]            rd_hit;
    logic [NCPU-1:0][NGRP-1:0]  irq_grp;

    assign wr.we   = reg_we;
    assign wr.addr = reg_addr;
    assign wr.data = reg_wdata;

    gpio_in_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pins_i    (pin_i),
        .wr_i      (wr),
        .pol_o     (pol),
        .data_in_o (data_in)
    );

    gpio_edge_cause u_cause (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .data_in_i (data_in),
        .rise_o    (rise),
        .cause_o   (cause)
    );

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_cpu
            gpio_cpu_route #(.CPU_ID(c)) u_route (
                .clk       (clk),
                .rst       (rst),
                .wr_i      (wr),
                .rd_addr_i (reg_addr),
                .data_in_i (data_in),
                .cause_i   (cause),
                .emsk_o    (emsk[c]),
                .lmsk_o    (lmsk[c]),
                .rd_hit_o  (rd_hit[c]),
                .rd_data_o (rd_val[c]),
                .irq_o     (irq_grp[c])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_POL:   reg_rdata = pol;
            REG_DIN:   reg_rdata = data_in;
            REG_CAUSE: reg_rdata = cause;
            default: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (rd_hit[c]) reg_rdata = rd_val[c];
                end
            end
        endcase
    end

    assign irq_cpu0 = irq_grp[0];
    assign irq_cpu1 = irq_grp[1];

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
    import gpio_irq_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    reg_we,
    input logic [7:0]              reg_addr,
    input logic [31:0]             reg_wdata,
    input logic [PINS-1:0]         data_in,
    input logic [PINS-1:0]         rise,
    input logic [PINS-1:0]         cause,
    input logic [NCPU-1:0][PINS-1:0] emsk,
    input logic [NCPU-1:0][PINS-1:0] lmsk,
    input logic [3:0]              irq_cpu0,
    input logic [3:0]              irq_cpu1
);

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((cause & $past(rise)) == $past(rise))); // R4 R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == REG_CAUSE) |=> ((cause & ~$past(reg_wdata) & ~$past(rise)) == '0)); // R5

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == REG_CAUSE) |=> ((cause & $past(cause)) == $past(cause))); // R5

    AST_SUM_CPU0: assert property (@(posedge clk) disable iff (rst)
        irq_cpu0 == group_or($past((data_in & lmsk[0]) | (cause & emsk[0])))); // R7 R9

    AST_SUM_CPU1: assert property (@(posedge clk) disable iff (rst)
        irq_cpu1 == group_or($past((data_in & lmsk[1]) | (cause & emsk[1])))); // R7 R9

    AST_QUIET_CPU0: assert property (@(posedge clk) disable iff (rst)
        (emsk[0] == '0 && lmsk[0] == '0) |=> (irq_cpu0 == '0)); // R8

    AST_QUIET_CPU1: assert property (@(posedge clk) disable iff (rst)
        (emsk[1] == '0 && lmsk[1] == '0) |=> (irq_cpu1 == '0)); // R8

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == REG_EMSK1) |=> $stable(emsk[1])); // R10

endmodule

bind dual_cpu_gpio_irq gpio_irq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .data_in   (data_in),
    .rise      (rise),
    .cause     (cause),
    .emsk      (emsk),
    .lmsk      (lmsk),
    .irq_cpu0  (irq_cpu0),
    .irq_cpu1  (irq_cpu1)
);

// File: tb/test_dual_cpu_gpio_irq.sv
module test_dual_cpu_gpio_irq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_i = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_cpu0;
    logic [3:0]  irq_cpu1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [7:0] A_POL = 8'h0C, A_DIN = 8'h10, A_CAUSE = 8'h14;
    localparam logic [7:0] A_E0 = 8'h18, A_L0 = 8'h1C, A_E1 = 8'h30, A_L1 = 8'h34;

    always #5 clk = ~clk;

    dual_cpu_gpio_irq i_dual_cpu_gpio_irq (
        .clk(clk), .rst(rst), .pin_i(pin_i), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_E0, 0); wr(A_L0, 0); wr(A_E1, 0); wr(A_L1, 0);
        wr(A_CAUSE, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq0", {28'd0, irq_cpu0}, 0);
        check("R1 irq1", {28'd0, irq_cpu1}, 0);
        rd("R1 cause", A_CAUSE, 0);
        rd("R1 e0", A_E0, 0); rd("R1 l0", A_L0, 0);
        rd("R1 e1", A_E1, 0); rd("R1 l1", A_L1, 0);

        // R2: distinct enable registers per processor
        wr(A_E0, 32'h1111_0001); wr(A_L0, 32'h2222_0002);
        wr(A_E1, 32'h4444_0004); wr(A_L1, 32'h8888_0008);
        rd("R2 e0", A_E0, 32'h1111_0001); rd("R2 l0", A_L0, 32'h2222_0002);
        rd("R2 e1", A_E1, 32'h4444_0004); rd("R2 l1", A_L1, 32'h8888_0008);
        clear_all();

        // R3/R4: inversion and edges from the inversion change
        @(negedge clk); pin_i = 32'h0000_FFFF;
        settle(4);
        wr(A_CAUSE, 0);
        wr(A_POL, 32'hFFFF_0000);
        rd("R3 pol", A_POL, 32'hFFFF_0000);
        rd("R3 din", A_DIN, 32'hFFFF_FFFF);
        settle(2);
        rd("R4 cause", A_CAUSE, 32'hFFFF_0000);
        // R5: zero bits clear, one bits keep
        wr(A_CAUSE, 32'h0F0F_FFFF);
        rd("R5 clear", A_CAUSE, 32'h0F0F_0000);
        wr(A_POL, 0);
        @(negedge clk); pin_i = 0;
        settle(4);
        wr(A_CAUSE, 0);
        rd("R5 empty", A_CAUSE, 0);

        // R10: unmapped and read-only offsets
        wr(8'h20, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF); wr(A_DIN, 32'hFFFF_FFFF);
        rd("R10 e0", A_E0, 0); rd("R10 l1", A_L1, 0);
        rd("R10 din", A_DIN, 0); rd("R10 unmapped", 8'h20, 0);
        check("R10 irq0", {28'd0, irq_cpu0}, 0);

        // R9: one-cycle latency from enable write
        @(negedge clk); pin_i = 32'h0000_0020;
        settle(5);
        wr(A_L0, 32'h0000_0020);
        check("R9 before", {28'd0, irq_cpu0}, 0);
        @(negedge clk);
        check("R9 after", {28'd0, irq_cpu0}, 1);
        wr(A_E1, 32'h0000_0020);
        check("R9 edge before", {28'd0, irq_cpu1}, 0);
        @(negedge clk);
        check("R9 edge after", {28'd0, irq_cpu1}, 1);
        clear_all();
        @(negedge clk); pin_i = 0;
        settle(4);
        wr(A_CAUSE, 0);

        // R6: clear and new edge in the same cycle
        wr(A_POL, 32'h0000_0020); wr(A_POL, 0);
        settle(2);
        @(negedge clk); pin_i = 32'h0000_0200;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = A_CAUSE; reg_wdata = 0;
        @(negedge clk); reg_we = 1'b0;
        rd("R6 edge wins", A_CAUSE, 32'h0000_0200);
        @(negedge clk); pin_i = 0;
        settle(4);
        wr(A_CAUSE, 0);

        // R7/R8: sweep every line, processor and mode
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 32; p++) begin
                logic [3:0] g;
                g = 4'(1 << (p / 8));
                // level mode
                wr(c == 0 ? A_L0 : A_L1, 32'(1) << p);
                @(negedge clk); pin_i = 32'(1) << p;
                settle(5);
                check($sformatf("R7 lvl c%0d p%0d", c, p), {28'd0, (c == 0) ? irq_cpu0 : irq_cpu1}, {28'd0, g});
                check($sformatf("R8 lvl c%0d p%0d", c, p), {28'd0, (c == 0) ? irq_cpu1 : irq_cpu0}, 0);
                @(negedge clk); pin_i = 0;
                settle(5);
                check($sformatf("R7 lvl low c%0d p%0d", c, p), {28'd0, (c == 0) ? irq_cpu0 : irq_cpu1}, 0);
                clear_all();
                // edge mode: a short pulse stays latched
                wr(c == 0 ? A_E0 : A_E1, 32'(1) << p);
                @(negedge clk); pin_i = 32'(1) << p;
                settle(3);
                pin_i = 0;
                settle(5);
                check($sformatf("R7 edge c%0d p%0d", c, p), {28'd0, (c == 0) ? irq_cpu0 : irq_cpu1}, {28'd0, g});
                check($sformatf("R8 edge c%0d p%0d", c, p), {28'd0, (c == 0) ? irq_cpu1 : irq_cpu0}, 0);
                rd($sformatf("R4 cause p%0d", p), A_CAUSE, 32'(1) << p);
                wr(A_CAUSE, ~(32'(1) << p));
                settle(1);
                check($sformatf("R5 edge clr c%0d p%0d", c, p), {28'd0, (c == 0) ? irq_cpu0 : irq_cpu1}, 0);
                clear_all();
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule